// File: doc/BRIEF.md
# SPI Target Register-Access Bridge

This block lets an external SPI host read and write a 32-bit addressed register space inside the chip, one byte at a time, over a single-lane SPI link. The link runs in mode 0. SCLK, chip select and MOSI are oversampled in the system clock domain. The SCLK frequency is therefore expected to stay well below one eighth of the system clock. Each frame starts when chip select falls and ends when it rises. The first byte of a frame is an opcode.

An access has two phases. First the host sends a configuration frame. It carries the start address and the byte count minus one, both as 32-bit values sent least-significant byte first. The host then polls an 8-bit sticky status word until the configuration is reported ready. After that it sends a separate data frame. A read-data frame returns bytes from consecutive addresses. A write-data frame pushes bytes to consecutive addresses. On the internal side, every byte becomes one request/acknowledge transaction on a simple byte-wide bus. Errors, completion and time-outs collect in the status word. The host clears the error bits with a write-one-to-clear status command.

The bridge keeps its own copy of one control bit, the early-transmit enable. It picks this bit out of writes to the internal control word at address 0x2000. When the bit is set, the bridge launches each following MISO bit right after the SCLK rising edge on which the previous bit was sampled, instead of at the falling edge.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset the status word reads 0x00, MISO is low and no bus request is pending.
- R2: Opcode 0x04 sets status bit 0 and opcode 0x02 clears it. Opcode 0x06 followed by one dummy byte returns the status word in the second byte slot.
- R3: Opcode 0x0A (read) or 0x0C (write) is followed by 4 address bytes and then 4 count-minus-one bytes, each group least-significant byte first. When the opcode arrives, status bits 1, 2 and 5 clear. A valid configuration then sets bits 1 and 2 together.
- R4: A count-minus-one value above 0xFFFE is rejected with status bit 7 and leaves bits 1 and 2 clear. The value 0xFFFE is accepted.
- R5: After a write configuration with count N, opcode 0x0E turns the next N bytes into bus writes at address, address+1, and so on. Any further bytes in the frame are dropped. Status bit 5 sets after the N-th write is acknowledged.
- R6: After a read configuration with count N, opcode 0x81 returns the bytes read from address, address+1, and so on. The first of them comes in the slot right after the opcode. Status bit 5 sets when the N-th slot completes.
- R7: Opcode 0x81 without a pending read configuration sets bit 3. Opcode 0x0E without a pending write configuration sets bit 4. Neither starts a bus request. A configuration is used up by a finished or aborted data phase.
- R8: An unknown opcode sets bit 7, and the remaining bytes of its frame cause no bus request.
- R9: Opcode 0x08 followed by a byte M clears each of the status bits 3, 4, 6 and 7 that is set in M. The other bits are unchanged, and error bits clear no other way.
- R10: If a bus request gets no acknowledge for the programmed number of cycles, the bridge drops the request, sets status bit 6 and aborts the data phase.
- R11: Opcode 0x10 with argument 0x04 is accepted silently. Any other argument sets bit 7.
- R12: Writing 1 to bit 0 of the byte at address 0x2002 (bit 16 of the word at 0x2000) enables early transmit. From then on, MISO presents bit k-1 shortly after the rising edge that samples bit k.
- R13: Raising chip select ends a command. A configuration frame cut short leaves no valid configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from host, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| ack_limit | input | TMO_W | Cycles a bus request may wait for acknowledge |
| bus_req | output | 1 | Internal bus request, held until acknowledge or time-out |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_wdata | output | 8 | Write data byte |
| bus_rdata | input | 8 | Read data byte, valid with acknowledge |
| bus_ack | input | 1 | One-cycle acknowledge |

## Verification
Each data burst is driven from the host side and compared against a scoreboard of the bus writes it should produce. Write bursts carry an extra trailing byte, which shows that the count limits the burst and not the frame length. Read bursts from the same addresses show that bytes land in the slot right after the opcode and come in address order. Misordered sequences are also driven: data frames without a configuration, frames with a bad opcode, an oversized count, a truncated configuration and a silent bus. In each case the status word is read back, which separates the error bits from one another and from the completion bit. MISO is also sampled both just before and just after each rising edge. This tells early-transmit timing apart from normal launch.

// File: rtl/spib_pkg.sv
// Shared constants for the SPI register bridge: opcodes, status bit
// positions and the command phase type. Assumes single-lane SPI only.
package spib_pkg;

    localparam logic [7:0] OP_PWR_OFF  = 8'h02;
    localparam logic [7:0] OP_PWR_ON   = 8'h04;
    localparam logic [7:0] OP_RD_STAT  = 8'h06;
    localparam logic [7:0] OP_WR_STAT  = 8'h08;
    localparam logic [7:0] OP_CFG_RD   = 8'h0A;
    localparam logic [7:0] OP_CFG_WR   = 8'h0C;
    localparam logic [7:0] OP_DATA_WR  = 8'h0E;
    localparam logic [7:0] OP_CFG_TYPE = 8'h10;
    localparam logic [7:0] OP_DATA_RD  = 8'h81;

    localparam logic [7:0] TYPE_SINGLE4 = 8'h04;

    localparam int SB_ON     = 0;
    localparam int SB_CFG_OK = 1;
    localparam int SB_READY  = 2;
    localparam int SB_RD_ERR = 3;
    localparam int SB_WR_ERR = 4;
    localparam int SB_DONE   = 5;
    localparam int SB_TMO    = 6;
    localparam int SB_CMD    = 7;

    localparam logic [7:0] ERR_MASK = 8'hD8;

    localparam int CFG_FIELD_W = 32;

    typedef enum logic [2:0] {
        PH_OP, PH_CFG, PH_CTYPE, PH_WSTAT, PH_RSTAT, PH_RDATA, PH_WDATA, PH_SKIP
    } phase_e;

endpackage

// File: rtl/spib_shifter.sv
// Byte shifter for a mode-0 SPI target. Synchronises SCLK, CS_N and MOSI
// into clk, assembles received bytes and shifts out the byte offered on
// tx_byte. Assumes SCLK is at most clk/8 so every edge is seen.
module spib_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       early_en,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       frame_start
);

    logic [2:0] sclk_q;
    logic [2:0] cs_q;
    logic [1:0] mosi_q;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       at_bound;
    logic       active;
    logic       rise;
    logic       fall;

    assign active      = ~cs_q[1];
    assign rise        = active & sclk_q[1] & ~sclk_q[2];
    assign fall        = active & ~sclk_q[1] & sclk_q[2];
    assign frame_start = ~cs_q[1] & cs_q[2];
    assign miso        = tx_sh[7];
    assign rx_byte     = rx_sh;

    // Purpose: bring the asynchronous pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    // Purpose: sample on rising edges, launch on falling (or early) edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            at_bound <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (frame_start) begin
                bit_cnt  <= '0;
                tx_sh    <= '0;
                at_bound <= 1'b0;
            end else if (!active) begin
                bit_cnt  <= '0;
                at_bound <= 1'b0;
            end else if (rise) begin
                rx_sh   <= {rx_sh[6:0], mosi_q[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    at_bound <= 1'b1;
                end else if (early_en) begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end else if (fall) begin
                if (at_bound) begin
                    tx_sh    <= tx_byte;
                    at_bound <= 1'b0;
                end else if (!early_en) begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    // R13: no byte is reported once chip select is high.
    assert_no_byte_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rx_valid);

    // R2: a received byte is a single-cycle pulse.
    assert_byte_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/spib_cmd.sv
// Command engine: decodes opcodes, holds the configured address and count,
// runs the byte-wide request/acknowledge bus and keeps the sticky status
// word. Assumes the bus answers well within one SPI bit time.
module spib_cmd
    import spib_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              LEN_W     = 16,
    parameter int              TMO_W     = 16,
    parameter logic [31:0]     CTRL_ADDR = 32'h0000_2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              frame_start,
    input  logic [TMO_W-1:0]  ack_limit,
    output logic [7:0]        tx_byte,
    output logic              early_en,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack
);

    localparam logic [ADDR_W-1:0] EARLY_ADDR = ADDR_W'(CTRL_ADDR + 32'd2);
    localparam logic [LEN_W-1:0]  LEN_BAD    = '1;

    phase_e                 ph;
    logic [2:0]             idx;
    logic [CFG_FIELD_W-1:0] addr_sh;
    logic [CFG_FIELD_W-1:0] len_sh;
    logic [CFG_FIELD_W-1:0] len_full;
    logic [ADDR_W-1:0]      cur_addr;
    logic [LEN_W-1:0]       rem_q;
    logic [TMO_W-1:0]       tmo_cnt;
    logic [7:0]             st_q;
    logic [7:0]             rd_buf;
    logic [7:0]             wdata_q;
    logic                   req_q;
    logic                   we_q;
    logic                   cfg_ok;
    logic                   cfg_rd;
    logic                   early_q;

    assign len_full  = {rx_byte, len_sh[CFG_FIELD_W-1:8]};
    assign bus_req   = req_q;
    assign bus_we    = we_q;
    assign bus_addr  = cur_addr;
    assign bus_wdata = wdata_q;
    assign early_en  = early_q;

    // Purpose: pick the byte shifted out in the next slot.
    always_comb begin
        case (ph)
            PH_RSTAT: tx_byte = st_q;
            PH_RDATA: tx_byte = rd_buf;
            default:  tx_byte = 8'h00;
        endcase
    end

    // Purpose: bus handshake, time-out, opcode decode and status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_OP;
            idx      <= '0;
            addr_sh  <= '0;
            len_sh   <= '0;
            cur_addr <= '0;
            rem_q    <= '0;
            tmo_cnt  <= '0;
            st_q     <= '0;
            rd_buf   <= '0;
            wdata_q  <= '0;
            req_q    <= 1'b0;
            we_q     <= 1'b0;
            cfg_ok   <= 1'b0;
            cfg_rd   <= 1'b0;
            early_q  <= 1'b0;
        end else begin
            if (req_q) begin
                if (bus_ack) begin
                    req_q   <= 1'b0;
                    tmo_cnt <= '0;
                    if (we_q) begin
                        if (cur_addr == EARLY_ADDR) early_q <= wdata_q[0];
                        if (rem_q == '0) begin
                            st_q[SB_DONE] <= 1'b1;
                            cfg_ok        <= 1'b0;
                            if (ph == PH_WDATA) ph <= PH_SKIP;
                        end else begin
                            rem_q    <= rem_q - 1'b1;
                            cur_addr <= cur_addr + 1'b1;
                        end
                    end else begin
                        rd_buf <= bus_rdata;
                    end
                end else if (tmo_cnt == ack_limit) begin
                    req_q        <= 1'b0;
                    tmo_cnt      <= '0;
                    st_q[SB_TMO] <= 1'b1;
                    cfg_ok       <= 1'b0;
                    if (ph == PH_RDATA || ph == PH_WDATA) ph <= PH_SKIP;
                end else begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                end
            end

            if (frame_start) begin
                ph  <= PH_OP;
                idx <= '0;
            end else if (rx_valid) begin
                case (ph)
                    PH_OP: begin
                        ph <= PH_SKIP;
                        case (rx_byte)
                            OP_PWR_OFF:  st_q[SB_ON] <= 1'b0;
                            OP_PWR_ON:   st_q[SB_ON] <= 1'b1;
                            OP_RD_STAT:  ph <= PH_RSTAT;
                            OP_WR_STAT:  ph <= PH_WSTAT;
                            OP_CFG_TYPE: ph <= PH_CTYPE;
                            OP_CFG_RD, OP_CFG_WR: begin
                                ph               <= PH_CFG;
                                idx              <= '0;
                                cfg_ok           <= 1'b0;
                                cfg_rd           <= (rx_byte == OP_CFG_RD);
                                st_q[SB_CFG_OK]  <= 1'b0;
                                st_q[SB_READY]   <= 1'b0;
                                st_q[SB_DONE]    <= 1'b0;
                            end
                            OP_DATA_RD: begin
                                if (cfg_ok && cfg_rd && !req_q) begin
                                    ph    <= PH_RDATA;
                                    req_q <= 1'b1;
                                    we_q  <= 1'b0;
                                end else begin
                                    st_q[SB_RD_ERR] <= 1'b1;
                                end
                            end
                            OP_DATA_WR: begin
                                if (cfg_ok && !cfg_rd) ph <= PH_WDATA;
                                else st_q[SB_WR_ERR] <= 1'b1;
                            end
                            default: st_q[SB_CMD] <= 1'b1;
                        endcase
                    end
                    PH_CFG: begin
                        idx <= idx + 3'd1;
                        if (idx < 3'd4) addr_sh <= {rx_byte, addr_sh[CFG_FIELD_W-1:8]};
                        else            len_sh  <= len_full;
                        if (idx == 3'd7) begin
                            ph <= PH_SKIP;
                            if (len_full[CFG_FIELD_W-1:LEN_W] == '0 &&
                                len_full[LEN_W-1:0] != LEN_BAD) begin
                                cfg_ok          <= 1'b1;
                                st_q[SB_CFG_OK] <= 1'b1;
                                st_q[SB_READY]  <= 1'b1;
                                cur_addr        <= addr_sh[ADDR_W-1:0];
                                rem_q           <= len_full[LEN_W-1:0];
                            end else begin
                                st_q[SB_CMD] <= 1'b1;
                            end
                        end
                    end
                    PH_CTYPE: begin
                        if (rx_byte != TYPE_SINGLE4) st_q[SB_CMD] <= 1'b1;
                        ph <= PH_SKIP;
                    end
                    PH_WSTAT: begin
                        st_q <= st_q & ~(rx_byte & ERR_MASK);
                        ph   <= PH_SKIP;
                    end
                    PH_RSTAT: ph <= PH_SKIP;
                    PH_RDATA: begin
                        if (rem_q == '0) begin
                            st_q[SB_DONE] <= 1'b1;
                            cfg_ok        <= 1'b0;
                            ph            <= PH_SKIP;
                        end else begin
                            rem_q    <= rem_q - 1'b1;
                            cur_addr <= cur_addr + 1'b1;
                            req_q    <= 1'b1;
                            we_q     <= 1'b0;
                        end
                    end
                    PH_WDATA: begin
                        wdata_q <= rx_byte;
                        req_q   <= 1'b1;
                        we_q    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: config-success and ready always move together.
    assert_ready_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[SB_CFG_OK] == st_q[SB_READY]);

    // R4: an accepted configuration never holds the oversize count.
    assert_len_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |-> rem_q != LEN_BAD);

    // R5: the address is held while a request waits.
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> !bus_req || $stable(bus_addr));

    // R10: a waiting request only goes away through the time-out.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req || st_q[SB_TMO]);

    // R9: error bits drop only after a write-status argument byte.
    assert_w1c_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q[SB_RD_ERR]) || $fell(st_q[SB_WR_ERR]) || $fell(st_q[SB_CMD])
        |-> $past(rx_valid && ph == PH_WSTAT));

endmodule

// File: rtl/spi_reg_bridge.sv
// Top of the SPI register bridge. Joins the SPI byte shifter and the
// command engine. Assumes mode-0 SPI with SCLK no faster than clk/8.
module spi_reg_bridge #(
    parameter int          ADDR_W    = 32,
    parameter int          LEN_W     = 16,
    parameter int          TMO_W     = 16,
    parameter logic [31:0] CTRL_ADDR = 32'h0000_2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [TMO_W-1:0]  ack_limit,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack
);

    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       frame_start;
    logic [7:0] tx_byte;
    logic       early_en;

    spib_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (spi_sclk),
        .cs_n        (spi_cs_n),
        .mosi        (spi_mosi),
        .early_en    (early_en),
        .tx_byte     (tx_byte),
        .miso        (spi_miso),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .frame_start (frame_start)
    );

    spib_cmd #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .TMO_W     (TMO_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .frame_start (frame_start),
        .ack_limit   (ack_limit),
        .tx_byte     (tx_byte),
        .early_en    (early_en),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ack     (bus_ack)
    );

endmodule

// File: tb/tb_spi_reg_bridge.sv
// Scoreboard bench: tasks act as SPI host, expected bus writes are queued
// and a monitor compares them with the writes the bridge issues.
module tb_spi_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] ack_limit = 16'd20;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_ack;

    int          checks = 0;
    int          errors = 0;
    int          req_count = 0;
    int          cycles = 0;
    logic        req_d;
    logic        no_ack = 1'b0;
    logic [1:0]  lat;
    logic [7:0]  mem [256];
    logic [39:0] exp_q [$];
    logic [7:0]  erx;
    logic [7:0]  st;
    logic [7:0]  d;

    always #2.5 clk = ~clk;

    spi_reg_bridge dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .ack_limit(ack_limit),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    // Bus target model with two-cycle acknowledge.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= 8'h00;
            lat       <= 2'd0;
        end else if (bus_req && !bus_ack && !no_ack) begin
            if (lat == 2'd1) begin
                bus_ack   <= 1'b1;
                lat       <= 2'd0;
                bus_rdata <= mem[bus_addr[7:0]];
                if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
            end else lat <= lat + 2'd1;
        end else begin
            bus_ack <= 1'b0;
            if (!bus_req) lat <= 2'd0;
        end
    end

    // Monitor: count requests, pop and compare every acknowledged write.
    always @(posedge clk) begin
        req_d <= bus_req;
        if (rst_n && bus_req && !req_d) req_count++;
        if (rst_n && bus_req && bus_ack && bus_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected write actual %h:%h expected none", bus_addr, bus_wdata);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                if (e != {bus_addr, bus_wdata}) begin
                    errors++;
                    $display("FAIL R5 write actual %h expected %h", {bus_addr, bus_wdata}, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <150000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); mosi = tx[i];
            repeat (7) @(negedge clk);
            rx[i] = miso; sclk = 1'b1;
            repeat (6) @(negedge clk);
            erx[i] = miso;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_lo();
        @(negedge clk); cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (4) @(negedge clk); cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        spi_byte(b, r);
    endtask

    task automatic rd_status(output logic [7:0] s);
        cs_lo(); send(8'h06); spi_byte(8'h00, s); cs_hi();
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_lo(); send(op); cs_hi();
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] arg);
        cs_lo(); send(op); send(arg); cs_hi();
    endtask

    task automatic config_cmd(input logic rd, input logic [31:0] a, input logic [31:0] m1);
        cs_lo();
        send(rd ? 8'h0A : 8'h0C);
        for (int i = 0; i < 4; i++) send(a[8*i +: 8]);
        for (int i = 0; i < 4; i++) send(m1[8*i +: 8]);
        cs_hi();
    endtask

    initial begin
        int rc;
        repeat (5) @(negedge clk);
        chk("R1 miso", {31'd0, miso}, 32'd0);
        chk("R1 req", {31'd0, bus_req}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        rd_status(st); chk("R1 status", st, 8'h00);

        cmd1(8'h04); rd_status(st); chk("R2 power on", st, 8'h01);
        cmd1(8'h02); rd_status(st); chk("R2 power off", st, 8'h00);
        cmd1(8'h04);

        config_cmd(1'b0, 32'h10, 32'd2);
        rd_status(st); chk("R3 cfg write ready", st, 8'h07);

        exp_q.push_back({32'h10, 8'hA1});
        exp_q.push_back({32'h11, 8'hB2});
        exp_q.push_back({32'h12, 8'hC3});
        cs_lo(); send(8'h0E); send(8'hA1); send(8'hB2); send(8'hC3); send(8'hD4); cs_hi();
        chk("R5 queue drained", exp_q.size(), 0);
        rd_status(st); chk("R5 done", st, 8'h27);

        config_cmd(1'b1, 32'h10, 32'd2);
        rd_status(st); chk("R3 cfg clears done", st, 8'h07);
        chk("R12 normal launch", erx, 8'h07);

        cs_lo(); send(8'h81);
        spi_byte(8'h00, d); chk("R6 byte0", d, 8'hA1);
        spi_byte(8'h00, d); chk("R6 byte1", d, 8'hB2);
        spi_byte(8'h00, d); chk("R6 byte2", d, 8'hC3);
        cs_hi();
        rd_status(st); chk("R6 done", st, 8'h27);

        rc = req_count;
        cmd2(8'h81, 8'h00); rd_status(st); chk("R7 read err", st, 8'h2F);
        cmd2(8'h0E, 8'h55); rd_status(st); chk("R7 write err", st, 8'h3F);
        chk("R7 no request", req_count - rc, 0);

        cmd2(8'h08, 8'hFF); rd_status(st); chk("R9 clear all", st, 8'h27);

        rc = req_count;
        cs_lo(); send(8'h55); send(8'h0E); send(8'h11); cs_hi();
        rd_status(st); chk("R8 bad opcode", st, 8'hA7);
        chk("R8 no request", req_count - rc, 0);
        cmd2(8'h08, 8'h10); rd_status(st); chk("R9 mask miss", st, 8'hA7);
        cmd2(8'h08, 8'h80); rd_status(st); chk("R9 partial clear", st, 8'h27);

        config_cmd(1'b0, 32'h20, 32'h0000FFFF);
        rd_status(st); chk("R4 oversize", st, 8'h81);
        cmd2(8'h08, 8'hFF);
        config_cmd(1'b0, 32'h20, 32'h0000FFFE);
        rd_status(st); chk("R4 max accepted", st, 8'h07);

        cmd2(8'h10, 8'h04); rd_status(st); chk("R11 type ok", st, 8'h07);
        cmd2(8'h10, 8'h05); rd_status(st); chk("R11 type bad", st, 8'h87);
        cmd2(8'h08, 8'hFF);

        cs_lo(); send(8'h0C); send(8'h01); send(8'h02); send(8'h03); cs_hi();
        rd_status(st); chk("R13 cut config", st, 8'h01);
        rc = req_count;
        cmd2(8'h0E, 8'h99); rd_status(st); chk("R13 no config", st, 8'h11);
        chk("R13 no request", req_count - rc, 0);
        cmd2(8'h08, 8'hFF);

        config_cmd(1'b1, 32'h40, 32'd0);
        no_ack = 1'b1;
        cs_lo(); send(8'h81); send(8'h00); cs_hi();
        chk("R10 req dropped", {31'd0, bus_req}, 32'd0);
        no_ack = 1'b0;
        rd_status(st); chk("R10 timeout", st, 8'h47);
        cmd2(8'h08, 8'h40); rd_status(st); chk("R9 clear timeout", st, 8'h07);

        config_cmd(1'b0, 32'h2002, 32'd0);
        exp_q.push_back({32'h2002, 8'h01});
        cmd2(8'h0E, 8'h01);
        chk("R12 ctrl write", exp_q.size(), 0);
        rd_status(st); chk("R12 status", st, 8'h27);
        chk("R12 early launch", {25'd0, erx[7:1]}, {25'd0, st[6:0]});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule